// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell

This block is one logic cell of a sum-of-products programmable device. It takes a shared input bus and the complement of every bus line. Seventeen programmable AND terms are built from these literals, and a configuration input selects which literals each term uses. The five lowest terms are control terms: two asynchronous clears, two clocks and an output enable. The twelve upper terms are grouped into three OR gates of four terms each, called the lower, middle and upper sums.

A 4-bit configuration selects two things. The first is whether the pin shows the first flop or a combinational sum, and how many sums are merged for that path. The second is the pin polarity. The two flops are always usable, whichever mode is chosen. The cell returns six feedback lines to the shared bus. Each flop advances on the rising edge of its own clock term, sampled by the system clock. A preset line shared by a bank of neighbouring cells can force a flop high at its clock edge.

Top module: `pldLogicCell`

## Requirements
- R1: After `rstN` is released, both flops read low, until a clock-term edge or a preset loads them.
- R2: The mask bits for term t are `andMask[t*2*BUS_W +: 2*BUS_W]`. The low BUS_W bits connect true bus lines and the high BUS_W bits connect complemented lines. A term is the AND of its connected literals, and it is 1 when no literal is connected. Term roles are: 0 clear flop 1, 1 clock flop 1, 2 clock flop 2, 3 clear flop 2, 4 output enable. Terms 5-8 form the lower sum, terms 9-12 the middle sum and terms 13-16 the upper sum.
- R3: A flop changes only on a system-clock edge where its clock term is 1 and was 0 at the previous edge. The new value is visible after that edge. A clock term held high does not load again.
- R4: When `cfg[2:0]` is 000, flop 1 loads middle|upper, flop 2 loads lower, and the pin shows flop 1. The unassigned codes 001, 011 and 111 behave exactly like 000.
- R5: When `cfg[2:0]` is 010, flop 1 loads lower|middle|upper, flop 2 loads lower, and the pin shows flop 1.
- R6: The combinational codes are 100, 101 and 110. They drive the pin from middle|upper, upper only, and lower|middle|upper respectively. In these codes flop 1 loads the middle sum and flop 2 loads the lower sum.
- R7: `cfg[3]`=1 drives the selected value to `pinOut` unchanged. `cfg[3]`=0 inverts it. This holds in both registered and combinational codes.
- R8: While a flop's clear term is 1, that flop reads low in the same cycle and its register is cleared. The clear overrides both the clock edge and the preset.
- R9: When `presetIn` is 1 at a flop's clock edge, that flop loads 1 whatever its sum input is. Without a clock edge the preset has no effect.
- R10: `fb` = {flop2, ~flop2, flop1, ~flop1, pin, ~pin}, with bit 5 first.
- R11: `pinOe` equals term 4. While it is 0, the pin feedback follows `pinIn`. While it is 1, the pin feedback follows `pinOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the clock terms |
| rstN | input | 1 | Active-low power-up clear |
| busIn | input | BUS_W | Shared input bus |
| andMask | input | 17*2*BUS_W | AND-array connection mask |
| cfg | input | 4 | Mode code in [2:0], polarity in [3] |
| presetIn | input | 1 | Bank-shared synchronous preset |
| pinIn | input | 1 | Externally driven pin level |
| pinOut | output | 1 | Value driven onto the pin |
| pinOe | output | 1 | Pin driver enable |
| fb | output | 6 | Feedback lines to the shared bus |

## Verification
A wrong flop value reaches `fb` one system-clock edge after the clock-term rise that loaded it. It also reaches the pin in that cycle whenever a registered code is selected. A mis-decoded mode is different: it shows up in `pinOut` in the same cycle as the bus pattern. Such a fault only becomes visible when the upper, middle and lower sums are driven differently. A clear or preset that wins in the wrong order shows only when both arrive at the same edge. The bench therefore drives each sum separately and stacks clear, clock and preset into one cycle.

// File: rtl/pldCellPkg.sv
package pldCellPkg;
  localparam int TERM_CNT      = 17;
  localparam int CTL_CNT       = 5;
  localparam int SUM_CNT       = 3;
  localparam int TERMS_PER_SUM = 4;
  localparam int FLOP_CNT      = 2;
  localparam int FB_W          = 6;

  // control-term positions; order is fixed by the cell's wiring
  localparam int T_CLR1 = 0;
  localparam int T_CK1  = 1;
  localparam int T_CK2  = 2;
  localparam int T_CLR2 = 3;
  localparam int T_OE   = 4;

  // sum indices
  localparam int S_LO  = 0;
  localparam int S_MID = 1;
  localparam int S_HI  = 2;

  typedef enum logic [2:0] {
    MODE_REG8   = 3'b000,
    MODE_REG12  = 3'b010,
    MODE_COMB8  = 3'b100,
    MODE_COMB4  = 3'b101,
    MODE_COMB12 = 3'b110
  } cellMode_e;

  typedef struct packed {
    logic [FLOP_CNT-1:0] clr;
    logic [FLOP_CNT-1:0] load;
    logic                selReg;
    logic                d1Lo;
    logic                d1Hi;
    logic                outLo;
    logic                outMid;
    logic                outHi;
    logic                activeHigh;
  } cellStrobes_t;
endpackage

// File: rtl/pldAndArray.sv
module pldAndArray #(
  parameter int BUS_W    = 8,
  parameter int TERM_CNT = 17
) (
  input  logic [BUS_W-1:0]            busIn,
  input  logic [TERM_CNT*2*BUS_W-1:0] andMask,
  output logic [TERM_CNT-1:0]         prodTerms
);
  localparam int LIT_W = 2 * BUS_W;

  logic [LIT_W-1:0] literals;
  assign literals = {~busIn, busIn};

  for (genvar t = 0; t < TERM_CNT; t++) begin : g_term
    logic [LIT_W-1:0] sel;
    assign sel          = andMask[t*LIT_W +: LIT_W];
    assign prodTerms[t] = &(literals | ~sel);
  end
endmodule

// File: rtl/pldCellCtrl.sv
module pldCellCtrl
  import pldCellPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         cfg,
  input  logic [T_CLR2:0]    ctlTerms,
  output cellStrobes_t       strobes
);
  logic ck1Prev, ck2Prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ck1Prev <= 1'b0;
      ck2Prev <= 1'b0;
    end else begin
      ck1Prev <= ctlTerms[T_CK1];
      ck2Prev <= ctlTerms[T_CK2];
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.clr[0]     = ctlTerms[T_CLR1];
    strobes.clr[1]     = ctlTerms[T_CLR2];
    strobes.load[0]    = ctlTerms[T_CK1] & ~ck1Prev;
    strobes.load[1]    = ctlTerms[T_CK2] & ~ck2Prev;
    strobes.activeHigh = cfg[3];
    case (cellMode_e'(cfg[2:0]))
      MODE_REG12: begin
        strobes.selReg = 1'b1;
        strobes.d1Lo   = 1'b1;
        strobes.d1Hi   = 1'b1;
      end
      MODE_COMB8: begin
        strobes.outMid = 1'b1;
        strobes.outHi  = 1'b1;
      end
      MODE_COMB4: begin
        strobes.outHi  = 1'b1;
      end
      MODE_COMB12: begin
        strobes.outLo  = 1'b1;
        strobes.outMid = 1'b1;
        strobes.outHi  = 1'b1;
      end
      default: begin
        strobes.selReg = 1'b1;
        strobes.d1Hi   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pldCellDatapath.sv
module pldCellDatapath
  import pldCellPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  cellStrobes_t                      strobes,
  input  logic [SUM_CNT*TERMS_PER_SUM-1:0]  sumTerms,
  input  logic                              oeTerm,
  input  logic                              presetIn,
  input  logic                              pinIn,
  output logic                              pinOut,
  output logic                              pinOe,
  output logic [FB_W-1:0]                   fb
);
  logic [SUM_CNT-1:0]  sums;
  logic [FLOP_CNT-1:0] dIn, qReg, qVis;
  logic                rawOut, pinLevel;

  for (genvar g = 0; g < SUM_CNT; g++) begin : g_sum
    assign sums[g] = |sumTerms[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  assign dIn[0] = sums[S_MID] | (strobes.d1Hi & sums[S_HI]) | (strobes.d1Lo & sums[S_LO]);
  assign dIn[1] = sums[S_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg <= '0;
    end else begin
      for (int k = 0; k < FLOP_CNT; k++) begin
        if (strobes.clr[k])       qReg[k] <= 1'b0;
        else if (strobes.load[k]) qReg[k] <= presetIn | dIn[k];
      end
    end
  end

  assign qVis = qReg & ~strobes.clr;

  always_comb begin
    if (strobes.selReg) rawOut = qVis[0];
    else rawOut = (strobes.outLo & sums[S_LO]) | (strobes.outMid & sums[S_MID]) |
                  (strobes.outHi & sums[S_HI]);
  end

  assign pinOut   = strobes.activeHigh ? rawOut : ~rawOut;
  assign pinOe    = oeTerm;
  assign pinLevel = oeTerm ? pinOut : pinIn;
  assign fb       = {qVis[1], ~qVis[1], qVis[0], ~qVis[0], pinLevel, ~pinLevel};
endmodule

// File: rtl/pldLogicCell.sv
module pldLogicCell
  import pldCellPkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [BUS_W-1:0]            busIn,
  input  logic [TERM_CNT*2*BUS_W-1:0] andMask,
  input  logic [3:0]                  cfg,
  input  logic                        presetIn,
  input  logic                        pinIn,
  output logic                        pinOut,
  output logic                        pinOe,
  output logic [FB_W-1:0]             fb
);
  logic [TERM_CNT-1:0] prodTerms;
  cellStrobes_t        strobes;

  pldAndArray #(.BUS_W(BUS_W), .TERM_CNT(TERM_CNT)) u_and (
    .busIn(busIn), .andMask(andMask), .prodTerms(prodTerms)
  );

  pldCellCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .ctlTerms(prodTerms[T_CLR2:0]), .strobes(strobes)
  );

  pldCellDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sumTerms(prodTerms[TERM_CNT-1:CTL_CNT]), .oeTerm(prodTerms[T_OE]),
    .presetIn(presetIn), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fb(fb)
  );
endmodule

// File: rtl/pldLogicCellChk.sv
module pldLogicCellChk
  import pldCellPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [TERM_CNT-1:0] prodTerms,
  input logic [3:0]          cfg,
  input logic                presetIn,
  input logic                pinIn,
  input logic                pinOut,
  input logic                pinOe,
  input logic [FB_W-1:0]     fb
);
  logic regCode;
  assign regCode = !(cfg[2:0] inside {3'b100, 3'b101, 3'b110});

  // R11
  tristate_pin_fb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> fb[1] == pinIn);

  // R11
  driven_pin_fb_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> fb[1] == pinOut);

  // R4
  reg_mode_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    regCode |-> pinOut == (cfg[3] ? fb[3] : !fb[3]));

  // R8
  clr1_force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    prodTerms[T_CLR1] |-> !fb[3]);

  // R8
  clr2_force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    prodTerms[T_CLR2] |-> !fb[5]);

  // R3
  q1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!prodTerms[T_CLR1] && !prodTerms[T_CK1]) |=> (prodTerms[T_CLR1] || $stable(fb[3])));

  // R3
  q2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!prodTerms[T_CLR2] && !prodTerms[T_CK2]) |=> (prodTerms[T_CLR2] || $stable(fb[5])));

  // R9
  preset_q1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (presetIn && $rose(prodTerms[T_CK1]) && !prodTerms[T_CLR1]) |=> (fb[3] || prodTerms[T_CLR1]));
endmodule

bind pldLogicCell pldLogicCellChk u_chk (
  .clk(clk), .rstN(rstN), .prodTerms(prodTerms), .cfg(cfg),
  .presetIn(presetIn), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .fb(fb)
);

// File: tb/pldLogicCell_tb.sv
`timescale 1ns/1ps
module pldLogicCell_tb;
  localparam int BUS_W  = 8;
  localparam int TERMS  = 17;
  localparam int LIT_W  = 2 * BUS_W;
  localparam int MASK_W = TERMS * LIT_W;

  typedef struct {
    logic       eOut;
    logic       eOe;
    logic [5:0] eFb;
    string      tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BUS_W-1:0]  busIn = '0;
  logic [MASK_W-1:0] andMask = '0;
  logic [3:0]        cfg = 4'b1000;
  logic              presetIn = 1'b0;
  logic              pinIn = 1'b0;
  logic              pinOut, pinOe;
  logic [5:0]        fb;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pldLogicCell #(.BUS_W(BUS_W)) u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .andMask(andMask), .cfg(cfg),
    .presetIn(presetIn), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .fb(fb)
  );

  // R10 encoding: {q2, ~q2, q1, ~q1, pin, ~pin}
  function automatic logic [5:0] fbOf(logic q2, logic q1, logic pin);
    return {q2, ~q2, q1, ~q1, pin, ~pin};
  endfunction

  // R2 layout: low half true literals, high half complements
  task automatic connectLit(int t, int line, bit inv);
    andMask[t*LIT_W + (inv ? BUS_W : 0) + line] = 1'b1;
  endtask

  task automatic step(logic [7:0] b, logic [3:0] c, logic pIn, logic pre,
                      logic eOut, logic eOe, logic q2, logic q1, logic ePin, string tag);
    expItem_t it;
    @(negedge clk);
    busIn = b; cfg = c; pinIn = pIn; presetIn = pre;
    it.eOut = eOut; it.eOe = eOe; it.eFb = fbOf(q2, q1, ePin); it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (pinOut !== it.eOut || pinOe !== it.eOe || fb !== it.eFb) begin
          fails++;
          $display("FAIL %s: got out=%b oe=%b fb=%b expected out=%b oe=%b fb=%b",
                   it.tag, pinOut, pinOe, fb, it.eOut, it.eOe, it.eFb);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // bus lines: 7 clr1, 6 ck1, 5 ck2, 4 clr2, 3 oe, 2 upper, 1 middle, 0 lower
  initial begin : driver
    connectLit(0, 7, 0);
    connectLit(1, 6, 0);
    connectLit(2, 5, 0);
    connectLit(3, 4, 0);
    connectLit(4, 3, 0);
    for (int s = 0; s < 3; s++) begin
      connectLit(5 + 4*s, s, 0);
      for (int k = 1; k < 4; k++) begin
        connectLit(5 + 4*s + k, 0, 0);
        connectLit(5 + 4*s + k, 0, 1);
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    step(8'h00, 4'b1000, 0, 0, 0, 0, 0, 0, 0, "R1 reset state");
    step(8'h0A, 4'b1000, 0, 0, 0, 1, 0, 0, 0, "R3 no edge no load");
    step(8'h4A, 4'b1000, 0, 0, 1, 1, 0, 1, 1, "R4 ck1 rise loads middle");
    step(8'h48, 4'b1000, 0, 0, 1, 1, 0, 1, 1, "R3 held clock no reload");
    step(8'h08, 4'b1000, 0, 0, 1, 1, 0, 1, 1, "R3 clock fall no load");
    step(8'h29, 4'b1000, 0, 0, 1, 1, 1, 1, 1, "R4 ck2 loads lower");
    step(8'h88, 4'b1000, 0, 0, 0, 1, 1, 0, 0, "R8 clear flop1");
    step(8'h18, 4'b1000, 0, 0, 0, 1, 0, 0, 0, "R8 clear flop2");
    step(8'h48, 4'b1000, 0, 1, 1, 1, 0, 1, 1, "R9 preset on ck1 edge only");
    step(8'hB8, 4'b1000, 0, 1, 0, 1, 0, 0, 0, "R8 clear beats preset and clock");
    step(8'h49, 4'b1010, 0, 0, 1, 1, 0, 1, 1, "R5 lower reaches flop1");
    step(8'h88, 4'b1010, 0, 0, 0, 1, 0, 0, 0, "R8 clear before R4 check");
    step(8'h49, 4'b1000, 0, 0, 0, 1, 0, 0, 0, "R4 lower not on flop1");
    step(8'h0C, 4'b1011, 0, 0, 0, 1, 0, 0, 0, "R4 code 011 registered");
    step(8'h4C, 4'b1011, 0, 0, 1, 1, 0, 1, 1, "R4 code 011 upper to flop1");
    step(8'h0C, 4'b1101, 0, 0, 1, 1, 0, 1, 1, "R6 mode101 upper");
    step(8'h0A, 4'b1101, 0, 0, 0, 1, 0, 1, 0, "R6 mode101 ignores middle");
    step(8'h0A, 4'b1100, 0, 0, 1, 1, 0, 1, 1, "R6 mode100 middle");
    step(8'h09, 4'b1100, 0, 0, 0, 1, 0, 1, 0, "R6 mode100 ignores lower");
    step(8'h09, 4'b1110, 0, 0, 1, 1, 0, 1, 1, "R6 mode110 lower");
    step(8'h09, 4'b0110, 0, 0, 0, 1, 0, 1, 0, "R7 active low comb");
    step(8'h08, 4'b0110, 0, 0, 1, 1, 0, 1, 1, "R7 active low idle");
    step(8'h08, 4'b0000, 0, 0, 0, 1, 0, 1, 0, "R7 active low registered");
    step(8'h88, 4'b1101, 0, 0, 0, 1, 0, 0, 0, "R8 clear in comb mode");
    step(8'h4A, 4'b1101, 0, 0, 0, 1, 0, 1, 0, "R6 middle feeds flop1 in comb");
    step(8'h29, 4'b1101, 0, 0, 0, 1, 1, 1, 0, "R6 lower feeds flop2 in comb");
    step(8'h00, 4'b1101, 1, 0, 0, 0, 1, 1, 1, "R11 disabled pin follows pinIn");
    step(8'h04, 4'b1101, 0, 0, 1, 0, 1, 1, 0, "R11 disabled pin ignores pinOut");
    step(8'h0C, 4'b1101, 1, 0, 1, 1, 1, 1, 1, "R10 enabled pin order");

    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule